// File: doc/BRIEF.md
# Octal DAC Serial Command Front End

This block is the digital front end of an eight-channel, 8-bit voltage DAC. A host drives a three-wire serial stream: a serial clock, a data line and an active-low frame strobe. The block samples all three into one system-clock domain. It shifts data bits, most significant first, into a 16-bit word register on each falling serial-clock edge, but only while the frame strobe is low.

A frame is acted on only when the strobe rises after at least 16 falling edges. A frame cut short is discarded. The committed word either loads one channel's 8-bit code, or powers down a set of channels with one of three output terminations. Power-down leaves the stored codes unchanged. A global bias-enable flag falls only when every channel is powered down.

The serial output carries the bits that leave the top of the shift register. It is held low for the first 16 edges of each frame, so that several devices can share one strobe and one clock in a chain. In such a chain the device nearest the host keeps the last 16 bits of a longer frame, and the next device keeps the 16 bits before them.

Top module: `octal_dac_cmd`

## Requirements
- R1: After reset all eight channel codes are 0, no channel is powered down, bias enable is 1 and the serial output is 0.
- R2: A write word has bit 15 = 0, the channel number (0..7) in bits 14:12 and the code in bits 11:4; bits 3:0 are ignored. The bits are sent most significant first, one per falling serial-clock edge while the strobe is low, and the write is applied after the strobe rises following the 16th edge.
- R3: If the strobe rises after fewer than 16 falling edges, no channel code, power-down flag or termination changes.
- R4: If a frame holds more than 16 falling edges, the last 16 bits received form the committed word.
- R5: The serial output is 0 from the strobe's falling edge until the 16th falling edge of that frame. After that it presents the bit that was shifted out, so a second device fed from it commits bits 31:16 of a 32-bit frame while the first device commits bits 15:0.
- R6: A word whose top nibble is 0xD, 0xE or 0xF powers down every channel whose bit is set in bits 7:0 (bit 0 = channel 0). The termination output is then 0 (high impedance), 1 (100 kΩ) or 2 (2.5 kΩ) respectively. Bits 11:8 are ignored, and channels whose mask bit is clear keep their state.
- R7: Power-down leaves every channel code intact. A later write to a channel clears its power-down flag.
- R8: Bias enable is 0 exactly when all eight channels are powered down.
- R9: A word whose top nibble is 0x8 to 0xC changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; data are taken on its falling edges |
| sdi_i | input | 1 | Serial data in |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdo_o | output | 1 | Serial data out for chaining |
| chan_code_o | output | 64 | Channel codes; channel n in bits 8n+7:8n |
| pd_flag_o | output | 8 | Power-down flag per channel |
| pd_term_o | output | 16 | Termination per channel; channel n in bits 2n+1:2n |
| bias_en_o | output | 1 | Bias enable; low only when all channels are down |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each level of the serial clock must last longer than the synchroniser depth plus one cycle. The data line must be steady around each falling edge, and the strobe must not move in the same system cycle as a serial-clock fall. The stimulus holds every serial-clock level for four system clocks and sets the data while the clock is high. It lowers the strobe four clocks before the first edge and raises it four clocks after the last edge. In a chain, the second device's data input changes only after the shared edge has been taken.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 8;
    localparam int N_CH   = 8;
    localparam int CH_W   = $clog2(N_CH);
    localparam int TERM_W = 2;

    typedef enum logic [TERM_W-1:0] {
        TERM_HIZ  = 2'd0,
        TERM_100K = 2'd1,
        TERM_2K5  = 2'd2
    } term_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PDOWN = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
        logic [N_CH-1:0]   mask;
        term_e             term;
    } cmd_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        cmd_t d;
        d.op   = OP_NONE;
        d.ch   = w[14:12];
        d.code = w[11:4];
        d.mask = w[7:0];
        d.term = TERM_HIZ;
        if (!w[15]) begin
            d.op = OP_WRITE;
        end else begin
            case (w[14:12])
                3'b101: begin d.op = OP_PDOWN; d.term = TERM_HIZ;  end
                3'b110: begin d.op = OP_PDOWN; d.term = TERM_100K; end
                3'b111: begin d.op = OP_PDOWN; d.term = TERM_2K5;  end
                default: d.op = OP_NONE;
            endcase
        end
        return d;
    endfunction
endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              frame_n_i,
    output logic              sdo_o,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [SYNC_STAGES-1:0] sclk_pipe, sdi_pipe, frm_pipe;
    logic sclk_s, sdi_s, frm_s, sclk_prev, frm_prev;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic full, sclk_fall, frm_rise, frm_fall;

    assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
    assign sdi_s     = sdi_pipe[SYNC_STAGES-1];
    assign frm_s     = frm_pipe[SYNC_STAGES-1];
    assign sclk_fall = sclk_prev & ~sclk_s;
    assign frm_rise  = ~frm_prev & frm_s;
    assign frm_fall  = frm_prev & ~frm_s;
    assign full      = (cnt == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_pipe  <= '1;
            frm_pipe   <= '1;
            sdi_pipe   <= '0;
            sclk_prev  <= 1'b1;
            frm_prev   <= 1'b1;
            shreg      <= '0;
            cnt        <= '0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            sclk_pipe  <= {sclk_pipe[SYNC_STAGES-2:0], sclk_i};
            sdi_pipe   <= {sdi_pipe[SYNC_STAGES-2:0], sdi_i};
            frm_pipe   <= {frm_pipe[SYNC_STAGES-2:0], frame_n_i};
            sclk_prev  <= sclk_s;
            frm_prev   <= frm_s;
            word_vld_o <= frm_rise & full;
            word_o     <= shreg;
            if (sclk_fall && !frm_s) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                if (!full) cnt <= cnt + 1'b1;
            end
            if (frm_fall) cnt <= '0;
        end
    end

    assign sdo_o = full ? shreg[WORD_W-1] : 1'b0;

    // R5
    sdo_quiet_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frm_s) |=> !sdo_o);
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
    import dac_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   word_vld_i,
    input  logic [WORD_W-1:0]      word_i,
    output logic [N_CH*CODE_W-1:0] code_o,
    output logic [N_CH-1:0]        pd_o,
    output logic [N_CH*TERM_W-1:0] term_o,
    output logic                   bias_o
);
    cmd_t cmd;
    logic [CODE_W-1:0] code_q [N_CH];
    term_e             term_q [N_CH];
    logic [N_CH-1:0]   pd_q;

    assign cmd = decode_word(word_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q <= '0;
            for (int i = 0; i < N_CH; i++) begin
                code_q[i] <= '0;
                term_q[i] <= TERM_HIZ;
            end
        end else if (word_vld_i) begin
            for (int i = 0; i < N_CH; i++) begin
                if (cmd.op == OP_WRITE && cmd.ch == CH_W'(i)) begin
                    code_q[i] <= cmd.code;
                    pd_q[i]   <= 1'b0;
                end else if (cmd.op == OP_PDOWN && cmd.mask[i]) begin
                    pd_q[i]   <= 1'b1;
                    term_q[i] <= cmd.term;
                end
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_flat
        assign code_o[g*CODE_W +: CODE_W] = code_q[g];
        assign term_o[g*TERM_W +: TERM_W] = term_q[g];
    end

    assign pd_o   = pd_q;
    assign bias_o = ~&pd_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (code_o == '0 && pd_o == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld_i |=> ($stable(code_o) && $stable(pd_o)));
    // R7
    pd_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && cmd.op == OP_PDOWN) |=> $stable(code_o));
    // R7
    write_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && cmd.op == OP_WRITE) |=> !pd_o[$past(cmd.ch)]);
    // R8
    bias_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && cmd.op == OP_WRITE) |=> bias_o);
    // R9
    other_ops_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && cmd.op == OP_NONE) |=> ($stable(code_o) && $stable(pd_o) && $stable(term_o)));
endmodule

// File: rtl/octal_dac_cmd.sv
module octal_dac_cmd
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sclk_i,
    input  logic                   sdi_i,
    input  logic                   frame_n_i,
    output logic                   sdo_o,
    output logic [N_CH*CODE_W-1:0] chan_code_o,
    output logic [N_CH-1:0]        pd_flag_o,
    output logic [N_CH*TERM_W-1:0] pd_term_o,
    output logic                   bias_en_o
);
    logic              word_vld;
    logic [WORD_W-1:0] word;

    dac_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk_i),
        .sdi_i      (sdi_i),
        .frame_n_i  (frame_n_i),
        .sdo_o      (sdo_o),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    dac_chan_bank bank_i (
        .clk        (clk),
        .rst        (rst),
        .word_vld_i (word_vld),
        .word_i     (word),
        .code_o     (chan_code_o),
        .pd_o       (pd_flag_o),
        .term_o     (pd_term_o),
        .bias_o     (bias_en_o)
    );
endmodule

// File: tb/octal_dac_cmd_tb.sv
module octal_dac_cmd_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1;
    logic sdi = 1'b0;
    logic frame_n = 1'b1;
    always #2 clk = ~clk;

    logic        sdo1, sdo2;
    logic [63:0] code_w [2];
    logic [7:0]  pd_w   [2];
    logic [15:0] term_w [2];
    logic        bias_w [2];

    octal_dac_cmd dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .frame_n_i(frame_n),
        .sdo_o(sdo1), .chan_code_o(code_w[0]), .pd_flag_o(pd_w[0]),
        .pd_term_o(term_w[0]), .bias_en_o(bias_w[0]));

    octal_dac_cmd dut2_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdo1), .frame_n_i(frame_n),
        .sdo_o(sdo2), .chan_code_o(code_w[1]), .pd_flag_o(pd_w[1]),
        .pd_term_o(term_w[1]), .bias_en_o(bias_w[1]));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] m_code [2][8];
    logic [7:0] m_pd   [2];
    logic [1:0] m_term [2][8];

    // Stimulus table: {bit count, stream}, stream sent from bit count-1 down to 0
    localparam int NV = 14;
    localparam logic [37:0] VEC [NV] = '{
        {6'd16, 32'h0000_1AB0},  // R2 write ch1 = AB
        {6'd16, 32'h0000_7FF0},  // R2 write ch7 = FF
        {6'd16, 32'h0000_0010},  // R2 write ch0 = 01
        {6'd10, 32'h0000_0355},  // R3 aborted
        {6'd15, 32'h0000_2660},  // R3 aborted at 15 edges
        {6'd20, 32'h000F_5230},  // R4 last 16 bits win
        {6'd32, 32'h3440_2990},  // R5 chained pair
        {6'd16, 32'h0000_D505},  // R6 high-Z on ch0, ch2
        {6'd16, 32'h0000_EAF0},  // R6 100k on ch4..7, bits 11:8 ignored
        {6'd16, 32'h0000_F30A},  // R8 2.5k on ch1, ch3: all down
        {6'd16, 32'h0000_0020},  // R7 wake ch0 with new code
        {6'd16, 32'h0000_90FF},  // R9 ignored class
        {6'd32, 32'hFFFF_1000},  // R8 second device all down
        {6'd16, 32'h0000_C0FF}   // R9 ignored class
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2:  return "R2";
            3, 4:     return "R3";
            5:        return "R4";
            6:        return "R5";
            7, 8:     return "R6";
            9, 12:    return "R8";
            10:       return "R7";
            default:  return "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_pd[d] = 8'h00;
            for (int c = 0; c < 8; c++) begin
                m_code[d][c] = 8'h00;
                m_term[d][c] = 2'd0;
            end
        end
    endtask

    task automatic model_word(input int d, input logic [15:0] w);
        if (!w[15]) begin
            m_code[d][w[14:12]] = w[11:4];
            m_pd[d][w[14:12]]   = 1'b0;
        end else if (w[15:12] >= 4'hD) begin
            for (int c = 0; c < 8; c++) begin
                if (w[c]) begin
                    m_pd[d][c]   = 1'b1;
                    m_term[d][c] = w[13:12] - 2'd1;
                end
            end
        end
    endtask

    task automatic model_frame(input logic [31:0] s, input int n);
        if (n >= 16) begin
            model_word(0, s[15:0]);
            model_word(1, s[31:16]);
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_dev(input int d, input string tag);
        logic [63:0] ec;
        logic [15:0] at, et;
        ec = '0; at = '0; et = '0;
        for (int c = 0; c < 8; c++) begin
            ec[c*8 +: 8] = m_code[d][c];
            if (m_pd[d][c]) begin
                et[c*2 +: 2] = m_term[d][c];
                at[c*2 +: 2] = term_w[d][c*2 +: 2];
            end
        end
        check(code_w[d] === ec, tag, $sformatf("dev%0d codes", d), code_w[d], ec);
        check(pd_w[d] === m_pd[d], tag, $sformatf("dev%0d pd", d), 64'(pd_w[d]), 64'(m_pd[d]));
        check(at === et, tag, $sformatf("dev%0d term", d), 64'(at), 64'(et));
        check(bias_w[d] === ~&m_pd[d], tag, $sformatf("dev%0d bias", d),
              64'(bias_w[d]), 64'(~&m_pd[d]));
    endtask

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic frame_open();
        frame_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(4);
        sclk = 1'b1;
    endtask

    task automatic frame_close();
        wait_clk(4);
        frame_n = 1'b1;
        wait_clk(12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int n;
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        check_dev(0, "R1");
        check_dev(1, "R1");
        check(sdo1 === 1'b0, "R1", "sdo after reset", 64'(sdo1), 64'd0);

        for (int v = 0; v < NV; v++) begin
            n = int'(VEC[v][37:32]);
            s = VEC[v][31:0];
            frame_open();
            for (int b = n - 1; b >= 0; b--) send_bit(s[b]);
            frame_close();
            model_frame(s, n);
            check_dev(0, vec_tag(v));
            check_dev(1, vec_tag(v));
        end

        // R5 serial output held low during the first 16 edges, then first bit
        s = 32'h0000_B0FF;
        frame_open();
        for (int b = 15; b >= 8; b--) send_bit(s[b]);
        wait_clk(3);
        check(sdo1 === 1'b0, "R5", "sdo mid frame", 64'(sdo1), 64'd0);
        for (int b = 7; b >= 0; b--) send_bit(s[b]);
        wait_clk(3);
        check(sdo1 === 1'b1, "R5", "sdo after 16 edges", 64'(sdo1), 64'd1);
        frame_close();
        model_frame(s, 16);
        check_dev(0, "R9");
        check_dev(1, "R5");

        // R1 reset from a busy state
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        model_reset();
        check_dev(0, "R1");
        check_dev(1, "R1");
        check(sdo1 === 1'b0, "R1", "sdo after second reset", 64'(sdo1), 64'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule